// File: doc/BRIEF.md
# Down-Counting Timer Channel with Two Compare Points

This block is one timer channel. A 32-bit counter is loaded from a programmable reload register and counts down by one on every tick. After it reaches zero it loads the reload value again and keeps running. Each tick comes from one of two sources, picked by a control input. One source is the system clock, which gives a tick every cycle. The other is a slow external tick line of about 1 MHz. That line is synchronized and edge-detected first, so each of its rising edges gives one tick.

Two compare registers mark points in the countdown. A compare value that is not below the reload value is treated as zero. The channel emits a one-cycle event pulse when the count lands on either effective nonzero compare value. It also emits one when the count lands on zero, but only if the overflow-event input is set or either effective compare value is zero.

Software can read the live count, the reload value and both compare values. While the channel runs, software can also overwrite the live count. The enable, source-select and overflow-event inputs come from a control register held outside this block, and the address decoding is also done outside.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, countOut, reloadOut, matchAOut and matchBOut are all zero and irqPulse is low.
- R2: While enable is low, countOut equals reloadOut, and a count write (wrCount) has no effect on countOut.
- R3: In the first cycle in which enable is high, countOut equals the reload value. With tickSel low, countOut then drops by one at every clock edge.
- R4: A tick taken while the count is zero loads the reload value, so one full cycle of the count lasts reload+1 ticks.
- R5: With tickSel high, the count moves only on external rising edges. It moves at the third clock edge after extTick is first seen high, and once per rising edge however long extTick stays high.
- R6: A compare value greater than or equal to the reload value acts as zero, both for matching and for the zero-event condition.
- R7: irqPulse is high for exactly the cycle in which countOut has just been stepped onto an effective nonzero compare value. Both compare points can fire in one cycle of the count.
- R8: irqPulse is high in the cycle in which countOut has just been stepped onto zero, but only if ovfIrqEn was high or either effective compare value is zero.
- R9: A count write while enabled sets countOut to wrData at the next edge, and counting continues from there. The write itself raises no event.
- R10: A write to the reload register or to either compare register appears on its read port after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal tick source |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel run control |
| tickSel | input | 1 | 1 selects the external tick, 0 selects the system clock |
| ovfIrqEn | input | 1 | Allows the event on reaching zero |
| extTick | input | 1 | Raw external tick line, asynchronous |
| wrCount | input | 1 | Write strobe for the live count |
| wrReload | input | 1 | Write strobe for the reload register |
| wrMatchA | input | 1 | Write strobe for compare register A |
| wrMatchB | input | 1 | Write strobe for compare register B |
| wrData | input | 32 | Write data shared by all write strobes |
| countOut | output | 32 | Live count when enabled, reload value otherwise |
| reloadOut | output | 32 | Reload register read-back |
| matchAOut | output | 32 | Compare register A read-back |
| matchBOut | output | 32 | Compare register B read-back |
| irqPulse | output | 1 | One-cycle event pulse |

## Verification
Register writes, count writes and internal ticks all show on the outputs one clock edge after they are applied. The event pulse appears at that same edge, together with the count value that caused it. External ticks add two synchronizer stages and one edge-detect stage, so the count moves at the third edge after the line rises. The bench drives inputs just after a rising edge and steps a reference model once per edge, using the same latency rules. It then compares every output one time unit after the following edge, so each result is checked in exactly the cycle it is due.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W     = 32;
  localparam int NUM_MATCH = 2;

  typedef struct packed {
    logic holdReload;
    logic loadWrite;
    logic step;
  } cntStrobe_t;
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawTick,
  output logic tickPulse
);
  localparam int LAST = STAGES;

  logic [LAST:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[LAST-1:0], rawTick};
  end

  assign tickPulse = shiftQ[LAST-1] & ~shiftQ[LAST];
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tickSel,
  input  logic       extPulse,
  input  logic       ovfIrqEn,
  input  logic       wrCount,
  input  logic       hitMatch,
  input  logic       hitZero,
  input  logic       anyMatchZero,
  output cntStrobe_t strobe,
  output logic       irqPulse
);
  logic tickEn;
  logic eventNext;
  logic irqQ;

  assign tickEn = tickSel ? extPulse : 1'b1;

  always_comb begin
    strobe.holdReload = ~enable;
    strobe.loadWrite  = enable & wrCount;
    strobe.step       = enable & ~wrCount & tickEn;
  end

  assign eventNext = strobe.step &
                     (hitMatch | (hitZero & (ovfIrqEn | anyMatchZero)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= eventNext;
  end

  assign irqPulse = irqQ;
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int NM = NUM_MATCH
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntStrobe_t          strobe,
  input  logic                wrReload,
  input  logic [NM-1:0]       wrMatch,
  input  logic [W-1:0]        wrData,
  output logic [W-1:0]        countQ,
  output logic [W-1:0]        reloadQ,
  output logic [NM-1:0][W-1:0] matchQ,
  output logic                hitMatch,
  output logic                hitZero,
  output logic                anyMatchZero
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]  nextStep;
  logic [NM-1:0] hitVec;
  logic [NM-1:0] zeroVec;

  assign nextStep = (countQ == '0) ? reloadQ : (countQ - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '0;
      reloadQ <= '0;
      matchQ  <= '0;
    end else begin
      if (strobe.holdReload)     countQ <= reloadQ;
      else if (strobe.loadWrite) countQ <= wrData;
      else if (strobe.step)      countQ <= nextStep;
      if (wrReload) reloadQ <= wrData;
      for (int i = 0; i < NM; i++) begin
        if (wrMatch[i]) matchQ[i] <= wrData;
      end
    end
  end

  for (genvar g = 0; g < NM; g++) begin : gCmp
    logic [W-1:0] effVal;
    assign effVal     = (matchQ[g] < reloadQ) ? matchQ[g] : '0;
    assign zeroVec[g] = (effVal == '0);
    assign hitVec[g]  = (nextStep != '0) && (nextStep == effVal);
  end

  assign hitMatch     = |hitVec;
  assign anyMatchZero = |zeroVec;
  assign hitZero      = (nextStep == '0);
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             tickSel,
  input  logic             ovfIrqEn,
  input  logic             extTick,
  input  logic             wrCount,
  input  logic             wrReload,
  input  logic             wrMatchA,
  input  logic             wrMatchB,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countOut,
  output logic [CNT_W-1:0] reloadOut,
  output logic [CNT_W-1:0] matchAOut,
  output logic [CNT_W-1:0] matchBOut,
  output logic             irqPulse
);
  cntStrobe_t                      strobe;
  logic                            extPulse;
  logic                            hitMatch;
  logic                            hitZero;
  logic                            anyMatchZero;
  logic [CNT_W-1:0]                countQ;
  logic [CNT_W-1:0]                reloadQ;
  logic [NUM_MATCH-1:0][CNT_W-1:0] matchQ;

  tick_sync #(.STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .rawTick(extTick), .tickPulse(extPulse)
  );

  timer_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tickSel(tickSel),
    .extPulse(extPulse), .ovfIrqEn(ovfIrqEn), .wrCount(wrCount),
    .hitMatch(hitMatch), .hitZero(hitZero), .anyMatchZero(anyMatchZero),
    .strobe(strobe), .irqPulse(irqPulse)
  );

  timer_datapath #(.W(CNT_W), .NM(NUM_MATCH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrReload(wrReload),
    .wrMatch({wrMatchB, wrMatchA}), .wrData(wrData),
    .countQ(countQ), .reloadQ(reloadQ), .matchQ(matchQ),
    .hitMatch(hitMatch), .hitZero(hitZero), .anyMatchZero(anyMatchZero)
  );

  assign countOut  = enable ? countQ : reloadQ;
  assign reloadOut = reloadQ;
  assign matchAOut = matchQ[0];
  assign matchBOut = matchQ[1];
endmodule

// File: rtl/dual_match_timer_chk.sv
module dual_match_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        ovfIrqEn,
  input logic        wrCount,
  input logic [31:0] wrData,
  input logic [31:0] countOut,
  input logic [31:0] reloadOut,
  input logic [31:0] matchAOut,
  input logic [31:0] matchBOut,
  input logic        irqPulse
);
  assert_start_from_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !$past(enable)) |-> (countOut == $past(reloadOut)));

  assert_step_or_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$past(wrCount) && countOut != $past(countOut)) |->
      ((countOut == $past(countOut) - 32'd1) ||
       ($past(countOut) == 32'd0 && countOut == $past(reloadOut))));

  assert_event_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(enable));

  assert_zero_event_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && countOut == 32'd0) |->
      ($past(ovfIrqEn) || $past(matchAOut) == 32'd0 || $past(matchBOut) == 32'd0 ||
       $past(matchAOut) >= $past(reloadOut) || $past(matchBOut) >= $past(reloadOut)));

  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && $past(wrCount) && enable) |->
      (!irqPulse && countOut == $past(wrData)));
endmodule

bind dual_match_timer dual_match_timer_chk uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .ovfIrqEn(ovfIrqEn),
  .wrCount(wrCount), .wrData(wrData), .countOut(countOut),
  .reloadOut(reloadOut), .matchAOut(matchAOut), .matchBOut(matchBOut),
  .irqPulse(irqPulse)
);

// File: tb/tb_dual_match_timer.sv
module tb_dual_match_timer;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0, tickSel = 1'b0, ovfIrqEn = 1'b0, extTick = 1'b0;
  logic        wrCount = 1'b0, wrReload = 1'b0, wrMatchA = 1'b0, wrMatchB = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] countOut, reloadOut, matchAOut, matchBOut;
  logic        irqPulse;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curReq = "R3";

  // reference model state
  logic [31:0] mCnt = '0, mRl = '0, mA = '0, mB = '0;
  logic        mIrq = 1'b0;
  logic        m1 = 1'b0, m2 = 1'b0, m3 = 1'b0;

  dual_match_timer dut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] eff(logic [31:0] m, logic [31:0] rl);
    return (m < rl) ? m : 32'd0;
  endfunction

  task automatic cycle();
    logic tickE;
    logic [31:0] nxt, eA, eB, nCnt;
    logic nIrq;
    tickE = tickSel ? (m2 & ~m3) : 1'b1;
    eA = eff(mA, mRl);
    eB = eff(mB, mRl);
    nxt = (mCnt == 0) ? mRl : mCnt - 32'd1;
    nIrq = 1'b0;
    nCnt = mCnt;
    if (!enable) nCnt = mRl;
    else if (wrCount) nCnt = wrData;
    else if (tickE) begin
      nCnt = nxt;
      nIrq = (nxt != 0 && (nxt == eA || nxt == eB)) ||
             (nxt == 0 && (ovfIrqEn || eA == 0 || eB == 0));
    end
    mCnt = nCnt;
    mIrq = nIrq;
    m3 = m2; m2 = m1; m1 = extTick;
    if (wrReload) mRl = wrData;
    if (wrMatchA) mA = wrData;
    if (wrMatchB) mB = wrData;
    @(posedge clk);
    #1;
    chk(curReq, countOut, enable ? mCnt : mRl);
    chk(curReq, {31'd0, irqPulse}, {31'd0, mIrq});
    chk("R10", reloadOut, mRl);
    chk("R10", matchAOut, mA);
    chk("R10", matchBOut, mB);
    wrCount = 0; wrReload = 0; wrMatchA = 0; wrMatchB = 0;
  endtask

  task automatic writeReg(int which, logic [31:0] v);
    wrData = v;
    case (which)
      0: wrCount = 1;
      1: wrReload = 1;
      2: wrMatchA = 1;
      default: wrMatchB = 1;
    endcase
    cycle();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1", countOut, 0);
    chk("R1", reloadOut, 0);
    chk("R1", matchAOut, 0);
    chk("R1", matchBOut, 0);
    chk("R1", {31'd0, irqPulse}, 0);
    rstN = 1;

    // R2: disabled reads reload, count write ignored
    curReq = "R2";
    writeReg(1, 32'd10);
    writeReg(0, 32'd99);
    run(3);

    // R3: enable starts at reload, internal tick
    curReq = "R3";
    enable = 1;
    run(5);

    // R4: wrap with overflow event enabled
    curReq = "R4";
    enable = 0;
    writeReg(1, 32'd3);
    ovfIrqEn = 1;
    enable = 1;
    run(10);

    // R7: two compare points inside one period
    curReq = "R7";
    enable = 0;
    ovfIrqEn = 0;
    writeReg(1, 32'd10);
    writeReg(2, 32'd7);
    writeReg(3, 32'd3);
    enable = 1;
    run(25);

    // R8: zero event suppressed with nonzero compares and ovf off
    curReq = "R8";
    run(12);

    // R6: compare at or above reload acts as zero
    curReq = "R6";
    writeReg(2, 32'd10);
    writeReg(3, 32'd50);
    run(24);

    // R9: live count write while running
    curReq = "R9";
    writeReg(2, 32'd4);
    writeReg(3, 32'd2);
    writeReg(0, 32'd6);
    run(3);
    writeReg(0, 32'd4);
    run(8);

    // R5: external tick, held-high level counts once
    curReq = "R5";
    tickSel = 1;
    run(3);
    extTick = 1;
    run(12);
    extTick = 0;
    run(3);
    for (int k = 0; k < 12; k++) begin
      extTick = 1; run(2);
      extTick = 0; run(2);
    end

    // random mix
    curReq = "R7";
    void'($urandom(1234));
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) enable = ~enable;
      else if (r < 5) tickSel = ~tickSel;
      else if (r < 7) ovfIrqEn = ~ovfIrqEn;
      if ($urandom_range(0, 3) == 0) extTick = ~extTick;
      r = $urandom_range(0, 99);
      if (r < 2) begin wrData = $urandom_range(0, 30); wrReload = 1; end
      else if (r < 4) begin wrData = $urandom_range(0, 35); wrMatchA = 1; end
      else if (r < 6) begin wrData = $urandom_range(0, 35); wrMatchB = 1; end
      else if (r < 7) begin wrData = $urandom_range(0, 30); wrCount = 1; end
      cycle();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule